// File: doc/BRIEF.md
# Serial Audio DAC Input Controller

This block is the digital front end of a two-channel audio converter in which one DAC core feeds two output integrate-and-hold stages. It runs on the serial bit clock. On every rising edge it samples four inputs: a serial data line, a word clock and a left/right clock, plus the static mode pins. The data is a 16-bit two's-complement word sent MSB first. Any number of bits may come before the word. When the word clock falls, the 16 bits shifted in most recently are moved into a parallel code register for the DAC core. The block also decodes the clocks and the mode pins into a per-channel integrate, hold or park state for the output amplifiers.

Two modes are supported. In shared mode (`mode_single` low) one converter serves both channels. The left/right clock tags each word, and the matching channel integrates while the word clock is high. In single-channel mode (`mode_single` high) the left output is parked at the common level. `dac_sel` then picks which tag of word the right output path accepts, and words with the other tag are inhibited.

A word-clock tracker FSM has three states: WS_INIT (no sample since reset), WS_HIGH (last sample high) and WS_LOW (last sample low). Its transitions are INIT→HIGH and LOW→HIGH on a high sample, INIT→LOW on a low sample, and HIGH→LOW on a low sample. Only the HIGH→LOW transition fires a transfer. Each channel has its own FSM with the states CH_HOLD, CH_INTEG and CH_PARK. Every edge recomputes the next state from the sampled inputs.

Top module: `serial_dac_front`

## Requirements
- R1: While `rst_n` is low, `code` is 0x0000, and `code_vld`, `code_left`, `integ_l`, `integ_r` and `park_l` are all 0.
- R2: Data is shifted in MSB first. Only the last 16 bits sampled before the transfer edge reach `code`, and any number of earlier leading bits is discarded.
- R3: A transfer happens on the first rising edge that samples `wclk` low after an edge that sampled it high. After that edge, `code` holds the 16 bits sampled on the 16 previous edges, and `code_vld` is high for exactly that one cycle. The data bit sampled on the transfer edge itself is not part of the word.
- R4: Sampling `wclk` low on several edges in a row gives only one transfer. A `wclk` that stays low after reset, with no high sample before it, gives none.
- R5: In shared mode, the transfer tags the word through `code_left`: `lrclk` sampled as 1 gives a left word (`code_left`=1), and `lrclk` sampled as 0 gives a right word (`code_left`=0). `dac_sel` has no effect in this mode.
- R6: In shared mode, after an edge that samples `wclk`=1, the channel named by `lrclk` integrates (`integ_l` for lrclk=1, `integ_r` for lrclk=0) and the other channel holds. After an edge that samples `wclk`=0, both channels hold.
- R7: In single-channel mode, `park_l` is 1 and `integ_l` is 0 after every edge.
- R8: In single-channel mode, `dac_sel`=0 accepts words with lrclk=1 and `dac_sel`=1 accepts words with lrclk=0. A word with the other tag is not latched: `code` keeps its value and `code_vld` stays 0. `integ_r` is 1 after an edge that samples `wclk`=1 with an accepted tag, and 0 after any other edge.
- R9: If the bit clock stops after the 16th data bit, no transfer takes place, even if `wclk` falls. The transfer happens on the next rising edge that arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; everything is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdata | input | 1 | Serial data, MSB first, two's complement |
| wclk | input | 1 | Word clock; a falling level triggers the transfer |
| lrclk | input | 1 | Left/right clock; 1 tags left, 0 tags right |
| mode_single | input | 1 | 0 = shared two-channel mode, 1 = single-channel mode |
| dac_sel | input | 1 | Single-channel mode word select: 0 left words, 1 right words |
| code | output | 16 | Latched two's-complement DAC code |
| code_vld | output | 1 | One-cycle strobe on each accepted transfer |
| code_left | output | 1 | Tag of the latched word: 1 left, 0 right |
| integ_l | output | 1 | Left output integrate enable |
| integ_r | output | 1 | Right output integrate enable |
| park_l | output | 1 | Left output parked at the common level |

## Verification
Every output is one register away from the sampled pins. The integrate enables, the park flag and the valid strobe therefore reflect the inputs of the most recent rising edge and are due one cycle after the stimulus. The bench drives each input right after an edge and reads the outputs 1 ns after the following edge. A transferred word shows up in `code` after the first low-`wclk` edge, not after the 16th data bit. The bench checks the strobe exactly there and checks again one edge later that it has dropped. For the stopped-clock case the bench gates the clock off. It then confirms that nothing changes while `wclk` is already low, and that the transfer appears after the single edge that follows.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

    // word-clock tracker states
    typedef enum logic [1:0] {
        WS_INIT = 2'd0,
        WS_HIGH = 2'd1,
        WS_LOW  = 2'd2
    } wfsm_e;

    // per-channel output stage states
    typedef enum logic [1:0] {
        CH_HOLD  = 2'd0,
        CH_INTEG = 2'd1,
        CH_PARK  = 2'd2
    } chst_e;

    localparam int unsigned NUM_CH = 2;
    localparam int unsigned CH_L   = 0;
    localparam int unsigned CH_R   = 1;

endpackage

// File: rtl/sadc_shift.sv
module sadc_shift #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    output logic [WORD_W-1:0] sreg
);

    // MSB arrives first, so each new bit enters at the LSB end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '0;
        end else begin
            sreg <= {sreg[WORD_W-2:0], sdata};
        end
    end

endmodule

// File: rtl/sadc_wordfsm.sv
module sadc_wordfsm
    import sadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    output logic xfer
);

    wfsm_e state_q;
    wfsm_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_INIT;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        xfer    = 1'b0;
        unique case (state_q)
            WS_INIT: state_d = wclk ? WS_HIGH : WS_LOW;
            WS_HIGH: begin
                if (!wclk) begin
                    state_d = WS_LOW;
                    xfer    = 1'b1;
                end
            end
            WS_LOW:  if (wclk) state_d = WS_HIGH;
            default: state_d = WS_INIT;
        endcase
    end

endmodule

// File: rtl/sadc_codereg.sv
module sadc_codereg #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer,
    input  logic              lrclk,
    input  logic              mode_single,
    input  logic              dac_sel,
    input  logic [WORD_W-1:0] sreg,
    output logic [WORD_W-1:0] code,
    output logic              code_vld,
    output logic              code_left
);

    logic accept;

    // single mode: sel 0 takes left-tagged (lr=1), sel 1 takes right-tagged (lr=0)
    always_comb begin
        accept = mode_single ? (lrclk ^ dac_sel) : 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code      <= '0;
            code_vld  <= 1'b0;
            code_left <= 1'b0;
        end else begin
            code_vld <= xfer & accept;
            if (xfer && accept) begin
                code      <= sreg;
                code_left <= lrclk;
            end
        end
    end

endmodule

// File: rtl/sadc_chanctl.sv
module sadc_chanctl
    import sadc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wclk,
    input  logic lrclk,
    input  logic mode_single,
    input  logic dac_sel,
    output logic integ_l,
    output logic integ_r,
    output logic park_l
);

    chst_e st_q [NUM_CH];
    chst_e st_d [NUM_CH];

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam bit IS_LEFT = (c == CH_L);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                st_q[c] <= CH_HOLD;
            end else begin
                st_q[c] <= st_d[c];
            end
        end

        always_comb begin
            st_d[c] = CH_HOLD;
            if (mode_single) begin
                if (IS_LEFT) begin
                    st_d[c] = CH_PARK;
                end else if (wclk && (lrclk ^ dac_sel)) begin
                    st_d[c] = CH_INTEG;
                end
            end else if (wclk && (lrclk == IS_LEFT)) begin
                st_d[c] = CH_INTEG;
            end
        end
    end

    always_comb begin
        integ_l = 1'b0;
        integ_r = 1'b0;
        park_l  = 1'b0;
        unique case (st_q[CH_L])
            CH_HOLD:  integ_l = 1'b0;
            CH_INTEG: integ_l = 1'b1;
            CH_PARK:  park_l  = 1'b1;
            default:  integ_l = 1'b0;
        endcase
        unique case (st_q[CH_R])
            CH_HOLD:  integ_r = 1'b0;
            CH_INTEG: integ_r = 1'b1;
            default:  integ_r = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front #(
    parameter int unsigned WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdata,
    input  logic              wclk,
    input  logic              lrclk,
    input  logic              mode_single,
    input  logic              dac_sel,
    output logic [WORD_W-1:0] code,
    output logic              code_vld,
    output logic              code_left,
    output logic              integ_l,
    output logic              integ_r,
    output logic              park_l
);

    logic [WORD_W-1:0] sreg;
    logic              xfer;

    sadc_shift #(.WORD_W(WORD_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .sdata (sdata),
        .sreg  (sreg)
    );

    sadc_wordfsm u_wfsm (
        .clk   (clk),
        .rst_n (rst_n),
        .wclk  (wclk),
        .xfer  (xfer)
    );

    sadc_codereg #(.WORD_W(WORD_W)) u_code (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer        (xfer),
        .lrclk       (lrclk),
        .mode_single (mode_single),
        .dac_sel     (dac_sel),
        .sreg        (sreg),
        .code        (code),
        .code_vld    (code_vld),
        .code_left   (code_left)
    );

    sadc_chanctl u_chan (
        .clk         (clk),
        .rst_n       (rst_n),
        .wclk        (wclk),
        .lrclk       (lrclk),
        .mode_single (mode_single),
        .dac_sel     (dac_sel),
        .integ_l     (integ_l),
        .integ_r     (integ_r),
        .park_l      (park_l)
    );

endmodule

// File: rtl/sadc_checker.sv
module sadc_checker #(
    parameter int unsigned WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wclk,
    input logic              dac_sel,
    input logic [WORD_W-1:0] code,
    input logic              code_vld,
    input logic              code_left,
    input logic              integ_l,
    input logic              integ_r,
    input logic              park_l
);

    // R3
    vld_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |=> !code_vld);

    // R3
    code_only_on_vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code != $past(code)) |-> code_vld);

    // R4
    vld_needs_low_wclk_chk: assert property (@(posedge clk) disable iff (!rst_n)
        code_vld |-> !$past(wclk));

    // R6
    no_dual_integ_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(integ_l && integ_r));

    // R7
    park_blocks_left_chk: assert property (@(posedge clk) disable iff (!rst_n)
        park_l |-> !integ_l);

    // R8
    single_tag_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code_vld && park_l) |-> (code_left == !$past(dac_sel)));

endmodule

bind serial_dac_front sadc_checker #(.WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wclk      (wclk),
    .dac_sel   (dac_sel),
    .code      (code),
    .code_vld  (code_vld),
    .code_left (code_left),
    .integ_l   (integ_l),
    .integ_r   (integ_r),
    .park_l    (park_l)
);

// File: tb/serial_dac_front_bench.sv
`timescale 1ns/1ps
module serial_dac_front_bench;

    logic        clk = 1'b0;
    logic        clk_en = 1'b1;
    logic        rst_n = 1'b0;
    logic        sdata = 1'b0;
    logic        wclk = 1'b0;
    logic        lrclk = 1'b0;
    logic        mode_single = 1'b0;
    logic        dac_sel = 1'b0;
    logic [15:0] code;
    logic        code_vld, code_left, integ_l, integ_r, park_l;

    int total = 0;
    int bad = 0;
    logic [15:0] exp_code = 16'h0000;

    // 200 MHz, gateable so the clock can be stopped low
    always #2.5 clk = clk_en ? ~clk : 1'b0;

    serial_dac_front u_serial_dac_front (
        .clk(clk), .rst_n(rst_n), .sdata(sdata), .wclk(wclk), .lrclk(lrclk),
        .mode_single(mode_single), .dac_sel(dac_sel), .code(code),
        .code_vld(code_vld), .code_left(code_left), .integ_l(integ_l),
        .integ_r(integ_r), .park_l(park_l)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [15:0] pick_val(input int k);
        case (k)
            0: return 16'h7FFF;
            1: return 16'h8000;
            2: return 16'h0000;
            3: return 16'hFFFF;
            default: return 16'((k * 40503) ^ 23130);
        endcase
    endfunction

    // expected outputs after an edge that sampled (w, lr) - R6, R7, R8
    task automatic check_chan(input logic w, input logic lr);
        logic eil, eir;
        eil = !mode_single && lr && w;
        eir = w && (mode_single ? (lr ^ dac_sel) : !lr);
        check(mode_single ? "R7 integ_l" : "R6 integ_l", integ_l, eil);
        check(mode_single ? "R8 integ_r" : "R6 integ_r", integ_r, eir);
        check("R7 park_l", park_l, mode_single);
    endtask

    task automatic send_word(input logic [15:0] v, input int nlead, input logic lr);
        logic acc;
        acc = mode_single ? (lr ^ dac_sel) : 1'b1;
        for (int i = 0; i < nlead + 16; i++) begin
            wclk  = 1'b1;
            lrclk = lr;
            sdata = (i < nlead) ? ~v[i % 16] : v[15 - (i - nlead)];
            tick();
            check_chan(1'b1, lr);
            check("R3 no early vld", code_vld, 1'b0);
        end
        wclk  = 1'b0;
        sdata = ~v[15];
        tick();
        if (acc) exp_code = v;
        check(acc ? "R2 code" : "R8 code kept", code, exp_code);
        check(acc ? "R3 vld" : "R8 vld inhibited", code_vld, acc);
        if (acc) check(mode_single ? "R8 tag" : "R5 tag", code_left, lr);
        check_chan(1'b0, lr);
        tick();
        check("R4 single transfer", code_vld, 1'b0);
        check("R4 code stable", code, exp_code);
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #12;
        // R1 reset state
        check("R1 code", code, 16'h0000);
        check("R1 vld", code_vld, 1'b0);
        check("R1 tag", code_left, 1'b0);
        check("R1 integ_l", integ_l, 1'b0);
        check("R1 integ_r", integ_r, 1'b0);
        check("R1 park", park_l, 1'b0);
        rst_n = 1'b1;
        // R4: low word clock after reset gives no transfer
        for (int i = 0; i < 4; i++) begin
            sdata = 1'b1;
            tick();
            check("R4 no transfer after reset", code_vld, 1'b0);
            check("R4 code after reset", code, 16'h0000);
        end
        // sweep modes, selects, tags, values and lead lengths
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 2; s++) begin
                mode_single = m[0];
                dac_sel     = s[0];
                for (int k = 0; k < 7; k++) begin
                    for (int l = 0; l < 2; l++) begin
                        send_word(pick_val(k + l + 3 * s), (k * 3 + l) % 9, l[0]);
                    end
                end
            end
        end
        // R9: stopped clock after bit 16
        mode_single = 1'b0;
        for (int i = 0; i < 16; i++) begin
            wclk  = 1'b1;
            lrclk = 1'b1;
            sdata = pick_val(9)[15 - i];
            tick();
        end
        clk_en = 1'b0;
        #3;
        wclk = 1'b0;
        #40;
        check("R9 no transfer while stopped", code_vld, 1'b0);
        check("R9 code unchanged", code, exp_code);
        clk_en = 1'b1;
        tick();
        exp_code = pick_val(9);
        check("R9 transfer on next edge", code_vld, 1'b1);
        check("R9 code", code, exp_code);
        check("R5 tag left", code_left, 1'b1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule